// File: doc/BRIEF.md
# Power-Signature Watermark Generator

This block imprints an ownership mark on a chip's supply current rather than on any logic output. A bank of registers is switched on purpose. All of them invert together in each cycle in which the mark calls for activity, and they hold in the other cycles. The extra switching adds a current component whose pattern over time carries the signature. An off-chip measurement can later recover it by correlation.

Two modes choose where the mark comes from. In spread-spectrum mode, a maximal-length linear feedback shift register yields one pseudo-random mark bit per cycle. The bank toggles in the cycles where that bit is 1. In input-modulated mode, the bank toggles only in cycles where a functional input bus equals a secret pattern fixed by parameter. A global enable freezes both the generator and the bank. The current mark bit is brought out on a debug tap.

Top module: `pwr_sig_wm`

## Requirements
- R1: After reset the generator holds the parameter seed (default 16'hACE1), every bank bit is 0, and the debug tap shows bit 0 of the seed.
- R2: While the enable is high, the generator advances once per cycle as a right-shifting Galois register. The next state is state>>1, XORed with mask 16'hB400 when bit 0 of the state is 1. The debug tap is bit 0 of the current state.
- R3: While the enable is low, the generator state does not change, so the debug tap keeps its value.
- R4: While the enable is low, no bank bit changes, whatever the mode and input.
- R5: In spread-spectrum mode (mode input 0) with enable high, every bank bit inverts at the next edge when the debug tap is 1.
- R6: In spread-spectrum mode with enable high, the bank holds when the debug tap is 0.
- R7: In input-modulated mode (mode input 1) with enable high, every bank bit inverts at the next edge when the input bus equals the secret pattern (default 8'h5A), whatever the tap value.
- R8: In input-modulated mode, the bank holds for any input value other than the secret pattern, whatever the tap value.
- R9: The generator never reaches the all-zero state. Over one full period of 65535 enabled cycles, the tap shows exactly 32768 ones.
- R10: All bank bits carry the same value at all times, so the switching of the whole bank adds up in one direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = spread-spectrum, 1 = input-modulated |
| en_i | input | 1 | Global enable for generator and bank |
| data_i | input | DATA_W (8) | Functional bus compared against the secret pattern |
| load_o | output | LOAD_N (32) | Toggling bank, the deliberate switching load |
| wm_bit_o | output | 1 | Debug tap of the current mark bit |

## Verification
A wrong generator state shows on the debug tap in the same cycle. It also shows on the bank one edge later, as a toggle or a hold that does not match the pseudo-random sequence. So comparing the tap against a reference sequence catches any divergence at once. An enable or match fault shows as a single bank edge that breaks the toggle/hold rule. A bank bit that slips out of step with the rest shows up as a mixed word on the next sample.

// File: rtl/pwr_sig_wm_pkg.sv
package pwr_sig_wm_pkg;

   typedef enum logic {
      WM_SPREAD = 1'b0,
      WM_MATCH  = 1'b1
   } wm_mode_e;

   // Galois right-shift feedback masks for maximal-length sequences
   function automatic logic [31:0] lfsr_mask(input int unsigned width);
      case (width)
         8:       lfsr_mask = 32'h0000_00B8;
         16:      lfsr_mask = 32'h0000_B400;
         default: lfsr_mask = 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/wm_lfsr.sv
module wm_lfsr #(
   parameter int unsigned  W    = 16,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         adv_i,
   output logic [W-1:0] state_o,
   output logic         bit_o
);
   import pwr_sig_wm_pkg::*;

   localparam logic [31:0]  MASK_FULL = lfsr_mask(W);
   localparam logic [W-1:0] MASK      = MASK_FULL[W-1:0];

   if (MASK_FULL == 32'h0) begin : g_bad_width
      $error("wm_lfsr: width has no feedback mask");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("wm_lfsr: seed must be nonzero");
   end

   logic [W-1:0] state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (adv_i) begin
         state_d = state_q >> 1;
         if (state_q[0]) state_d = state_d ^ MASK;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= SEED;
      else         state_q <= state_d;
   end

   assign state_o = state_q;
   assign bit_o   = state_q[0];

   // R3: frozen while not advancing
   p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(state_q));
   // R9: never locks up at zero
   p_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != '0);

endmodule

// File: rtl/wm_match.sv
module wm_match #(
   parameter int unsigned       DATA_W  = 8,
   parameter logic [DATA_W-1:0] PATTERN = 8'h5A
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              hit_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("wm_match: pattern too short to be secret");
   end

   assign hit_o = (data_i == PATTERN);

endmodule

// File: rtl/wm_load.sv
module wm_load #(
   parameter int unsigned N = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         act_i,
   output logic [N-1:0] bank_o
);
   if (N < 1) begin : g_bad_n
      $error("wm_load: bank must have at least one register");
   end

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    cell_q <= 1'b0;
         else if (act_i) cell_q <= ~cell_q;
      end
      assign bank_o[i] = cell_q;
   end

   // R4/R6/R8: no activity means the bank holds
   p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i |=> $stable(bank_o));
   // R5/R7: activity inverts every bit
   p_invert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> (bank_o == ~$past(bank_o)));
   // R10: bank moves as one
   p_uniform_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_o == '0) || (bank_o == '1));

endmodule

// File: rtl/pwr_sig_wm.sv
module pwr_sig_wm #(
   parameter int unsigned            LFSR_W  = 16,
   parameter logic [LFSR_W-1:0]      SEED    = 16'hACE1,
   parameter int unsigned            DATA_W  = 8,
   parameter logic [DATA_W-1:0]      PATTERN = 8'h5A,
   parameter int unsigned            LOAD_N  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [LOAD_N-1:0] load_o,
   output logic              wm_bit_o
);
   import pwr_sig_wm_pkg::*;

   wm_mode_e          mode;
   logic [LFSR_W-1:0] lfsr_state;
   logic              lfsr_bit;
   logic              hit;
   logic              act;

   assign mode = wm_mode_e'(mode_i);

   wm_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (en_i),
      .state_o (lfsr_state),
      .bit_o   (lfsr_bit)
   );

   wm_match #(.DATA_W(DATA_W), .PATTERN(PATTERN)) u_match (
      .data_i (data_i),
      .hit_o  (hit)
   );

   always_comb begin
      act = 1'b0;
      if (en_i) begin
         case (mode)
            WM_SPREAD: act = lfsr_bit;
            WM_MATCH:  act = hit;
            default:   act = 1'b0;
         endcase
      end
   end

   wm_load #(.N(LOAD_N)) u_load (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act),
      .bank_o (load_o)
   );

   assign wm_bit_o = lfsr_bit;

   // R8: off-pattern input in match mode never moves the bank
   p_nomatch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && mode_i && (data_i != PATTERN)) |=> $stable(load_o));
   // R4: disabled block keeps bank static
   p_disabled_static_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(load_o));
   // R6: spread mode with tap low keeps bank static
   p_spread_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !mode_i && !wm_bit_o) |=> $stable(load_o));

endmodule

// File: tb/pwr_sig_wm_tb.sv
module pwr_sig_wm_tb;

   localparam logic [15:0] SEED = 16'hACE1;
   localparam logic [7:0]  PAT  = 8'h5A;
   localparam int          NV   = 16;

   // {mode, en, data}
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b1, 8'h5A},
      {1'b0, 1'b0, 8'h12}, {1'b0, 1'b0, 8'h5A}, {1'b0, 1'b1, 8'h33},
      {1'b1, 1'b1, 8'h5A}, {1'b1, 1'b1, 8'h5B}, {1'b1, 1'b1, 8'hA5},
      {1'b1, 1'b1, 8'h5A}, {1'b1, 1'b0, 8'h5A}, {1'b1, 1'b1, 8'h00},
      {1'b1, 1'b1, 8'h5A}, {1'b1, 1'b1, 8'hDA}, {1'b0, 1'b1, 8'h01},
      {1'b1, 1'b1, 8'h1A}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  data = 8'h00;
   logic [31:0] load;
   logic        wm_bit;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [15:0] mdl = SEED;
   logic [31:0] exp_load = '0;
   logic        done = 1'b0;

   always #5 clk = ~clk;

   pwr_sig_wm u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .mode_i   (mode),
      .en_i     (en),
      .data_i   (data),
      .load_o   (load),
      .wm_bit_o (wm_bit)
   );

   function automatic logic [15:0] mdl_next(input logic [15:0] s);
      logic [15:0] n;
      n = {1'b0, s[15:1]};
      if (s[0]) n = n ^ 16'hB400;
      return n;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic e, input logic [7:0] d, input string tapreq);
      logic act;
      string req;
      @(negedge clk);
      mode = m; en = e; data = d;
      #1;
      chk(tapreq, {31'b0, wm_bit}, {31'b0, mdl[0]});
      if (!e) begin act = 1'b0; req = "R4"; end
      else if (!m) begin act = mdl[0]; req = mdl[0] ? "R5" : "R6"; end
      else begin act = (d == PAT); req = act ? "R7" : "R8"; end
      @(posedge clk);
      #1;
      if (act) exp_load = ~exp_load;
      chk(req, load, exp_load);
      chk("R10", {31'b0, (load == '0) || (load == '1)}, 32'd1);
      if (e) mdl = mdl_next(mdl);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=200000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int ones;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1", load, 32'h0);
      chk("R1", {31'b0, wm_bit}, {31'b0, SEED[0]});
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R2 tap check, and R3 after a disabled step
      for (int i = 0; i < NV; i++) begin
         logic prev_en;
         prev_en = (i > 0) ? VEC[i-1][8] : 1'b1;
         step(VEC[i][9], VEC[i][8], VEC[i][7:0], prev_en ? "R2" : "R3");
      end

      // R8 corner: match mode, pattern absent, tap high and low both seen
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, PAT ^ 8'h80, "R2");
      // R7 corner: pattern present, tap ignored
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, PAT, "R2");
      // R3/R4: long disabled run
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00, "R3");

      // R9: full period of the generator in spread mode
      @(negedge clk);
      mode = 1'b0; en = 1'b1; data = 8'h00;
      ones = 0;
      for (int i = 0; i < 65535; i++) begin
         #1;
         if (wm_bit !== mdl[0]) begin
            chk("R2", {31'b0, wm_bit}, {31'b0, mdl[0]});
         end
         if (wm_bit) ones++;
         mdl = mdl_next(mdl);
         @(negedge clk);
      end
      chk("R9", ones, 32'd32768);
      #1;
      chk("R9", {31'b0, wm_bit}, {31'b0, mdl[0]});
      en = 1'b0;

      // R1: reset mid-run restores seed and clears bank
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", load, 32'h0);
      chk("R1", {31'b0, wm_bit}, {31'b0, SEED[0]});

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule